// File: doc/BRIEF.md
# CPU Wait Generator with Watchdog

This block paces double-density disk transfers against the processor by stretching its bus cycles. Software turns wait generation on with a level enable. A processor access to the disk controller's data port then raises the wait line. The wait stays up until the controller raises its data request or signals the end of the transfer with its interrupt request, whichever comes first.

Waiting on an external controller can hang the processor. If the processor stalls for too long, its dynamic memory stops being refreshed and loses its contents. A hardware watchdog bounds every wait to a fixed number of clock cycles, set by a parameter. When the watchdog ends a wait, it sets a sticky flag that only reset clears, so software can tell afterwards that a transfer went wrong.

All inputs are sampled on the rising clock edge, and both outputs come straight from registers. The disk controller itself is outside this block.

Top module: `cpu_wait_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), cpu_wait and wd_expired are both 0.
- R2: When an edge samples wait_en=1, drq=0 and a rising edge of data_access (0 at the previous edge, 1 now), and no wait is in progress, cpu_wait is 1 from that edge onward.
- R3: With wait_en=0, a data_access edge raises no wait. An edge that samples wait_en=0 while a wait is in progress ends that wait.
- R4: An access seen while drq is already 1 raises no wait.
- R5: An edge that samples drq=1 during a wait drops cpu_wait and leaves wd_expired unchanged.
- R6: An edge that samples intrq=1 during a wait drops cpu_wait and leaves wd_expired unchanged.
- R7: An access is counted only on a 0-to-1 change of data_access, so a strobe held high raises at most one wait. Accesses that arrive while a wait is in progress are ignored and do not restart the watchdog.
- R8: If no release arrives, cpu_wait is high for exactly WD_LIMIT consecutive cycles. It then drops and wd_expired becomes 1 at the same edge.
- R9: wd_expired stays 1 until reset. Waits keep working normally after it is set.
- R10: The watchdog count restarts with every new wait, so a wait that follows an early release may again last the full WD_LIMIT cycles.
- R11: When a release (drq, intrq or wait_en=0) is sampled at the same edge at which the watchdog limit is reached, the release wins and wd_expired is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wait_en | input | 1 | Level enable for wait generation |
| data_access | input | 1 | Strobe, high while the processor accesses the controller data port |
| drq | input | 1 | Data request from the disk controller |
| intrq | input | 1 | Interrupt request from the disk controller, marks end of transfer |
| cpu_wait | output | 1 | Wait line to the processor, active high |
| wd_expired | output | 1 | Sticky flag, set when the watchdog ended a wait |

## Verification
If the hold state is wrong, the error appears on cpu_wait one clock later. A missed release shows as a wait that lasts one cycle too long. A spurious start shows as a wait with no matching access. If the watchdog counter does not restart between waits, or is off by one, the run length of cpu_wait differs from WD_LIMIT. In that case wd_expired appears one wait early or not at all. Every such error is visible at the ports within WD_LIMIT+1 cycles of the access that began the wait.

// File: rtl/cwg_pkg.sv
// Package: shared types for the CPU wait generator.
// Assumes: nothing beyond IEEE 1800-2017.
package cwg_pkg;

    // Hold state of the wait line controller
    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HOLD = 1'b1
    } hold_state_t;

endpackage

// File: rtl/cwg_edge_detect.sv
// Module: cwg_edge_detect
// Turns a level strobe into a one-cycle pulse on its 0-to-1 change.
// Assumes: strobe is synchronous to clk; the remembered level is 0 after reset.
module cwg_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic pulse
);

    logic strobe_q;

    // Remember the strobe level seen at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Pulse when the strobe is high now and was low before
    always_comb begin
        pulse = strobe & ~strobe_q;
    end

endmodule

// File: rtl/cwg_watchdog.sv
// Module: cwg_watchdog
// Counts cycles while a wait is held and signals when the limit is reached.
// Assumes: run drops for at least one cycle between waits, which clears the count.
module cwg_watchdog #(
    parameter int unsigned LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] count_q;

    // Count held cycles; restart from zero whenever no wait is held
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (!run)    count_q <= '0;
        else if (!expire) count_q <= count_q + 1'b1;
    end

    // Limit reached on this cycle of the wait
    always_comb begin
        expire = run && (count_q == LAST);
    end

endmodule

// File: rtl/cwg_hold_fsm.sv
// Module: cwg_hold_fsm
// Decides when the wait line rises and falls.
// Assumes: access_pulse lasts one cycle; expire comes from the watchdog.
// A release request wins over the watchdog in the same cycle.
module cwg_hold_fsm
    import cwg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic access_pulse,
    input  logic drq,
    input  logic intrq,
    input  logic expire,
    output logic holding,
    output logic wd_trip
);

    hold_state_t state_q, state_d;
    logic        release_req;
    logic        start_req;

    // Release and start conditions
    always_comb begin
        release_req = ~enable | drq | intrq;
        start_req   = enable & access_pulse & ~drq;
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        wd_trip = 1'b0;
        unique case (state_q)
            HS_IDLE: if (start_req) state_d = HS_HOLD;
            HS_HOLD: begin
                if (release_req) begin
                    state_d = HS_IDLE;
                end else if (expire) begin
                    state_d = HS_IDLE;
                    wd_trip = 1'b1;
                end
            end
            default: state_d = HS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // Wait is held exactly while in the hold state
    always_comb begin
        holding = (state_q == HS_HOLD);
    end

endmodule

// File: rtl/cpu_wait_gen.sv
// Module: cpu_wait_gen (top)
// Stretches processor accesses to the disk data port until the controller
// requests data or ends the transfer, bounded by a watchdog of WD_LIMIT cycles.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module cpu_wait_gen #(
    parameter int unsigned WD_LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_en,
    input  logic data_access,
    input  logic drq,
    input  logic intrq,
    output logic cpu_wait,
    output logic wd_expired
);

    logic access_pulse;
    logic holding;
    logic expire;
    logic wd_trip;
    logic expired_q;

    cwg_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (data_access),
        .pulse  (access_pulse)
    );

    cwg_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (holding),
        .expire (expire)
    );

    cwg_hold_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (wait_en),
        .access_pulse (access_pulse),
        .drq          (drq),
        .intrq        (intrq),
        .expire       (expire),
        .holding      (holding),
        .wd_trip      (wd_trip)
    );

    // Sticky record of a watchdog release
    always_ff @(posedge clk) begin
        if (!rst_n)       expired_q <= 1'b0;
        else if (wd_trip) expired_q <= 1'b1;
    end

    // Drive outputs from registers
    always_comb begin
        cpu_wait   = holding;
        wd_expired = expired_q;
    end

endmodule

// File: rtl/cwg_checker.sv
// Module: cwg_checker
// Port-level properties of cpu_wait_gen, bound to every instance.
module cwg_checker #(
    parameter int unsigned WD_LIMIT = 40
) (
    input logic clk,
    input logic rst_n,
    input logic wait_en,
    input logic data_access,
    input logic drq,
    input logic intrq,
    input logic cpu_wait,
    input logic wd_expired
);

    logic [31:0] run_len;

    // Length of the current run of wait cycles
    always_ff @(posedge clk) begin
        if (!rst_n)        run_len <= '0;
        else if (cpu_wait) run_len <= run_len + 1;
        else               run_len <= '0;
    end

    // R3
    no_wait_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_en |=> !cpu_wait);

    // R2
    wait_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_en && !drq && $rose(data_access) && !cpu_wait) |=> cpu_wait);

    // R5
    drq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && drq) |=> (!cpu_wait && $stable(wd_expired)));

    // R6
    intrq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && intrq) |=> (!cpu_wait && $stable(wd_expired)));

    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= WD_LIMIT);

    // R8
    expire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_expired) |-> (!cpu_wait && $past(cpu_wait)));

    // R9
    expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expired |=> wd_expired);

endmodule

bind cpu_wait_gen cwg_checker #(.WD_LIMIT(WD_LIMIT)) u_cwg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_en     (wait_en),
    .data_access (data_access),
    .drq         (drq),
    .intrq       (intrq),
    .cpu_wait    (cpu_wait),
    .wd_expired  (wd_expired)
);

// File: tb/cpu_wait_gen_bench.sv
module cpu_wait_gen_bench;

    localparam int LIM = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_en = 1'b0;
    logic data_access = 1'b0;
    logic drq = 1'b0;
    logic intrq = 1'b0;
    logic cpu_wait;
    logic wd_expired;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_wait = 0;
    int m_cnt = 0;
    int m_exp = 0;
    int m_prev = 0;

    always #5 clk = ~clk;

    cpu_wait_gen u_cpu_wait_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_en     (wait_en),
        .data_access (data_access),
        .drq         (drq),
        .intrq       (intrq),
        .cpu_wait    (cpu_wait),
        .wd_expired  (wd_expired)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wait = 0; m_cnt = 0; m_exp = 0; m_prev = 0;
        end else begin
            int rise;
            rise = (data_access && m_prev == 0) ? 1 : 0;
            m_prev = data_access ? 1 : 0;
            if (m_wait != 0) begin
                if (!wait_en || drq || intrq) begin
                    m_wait = 0; m_cnt = 0;
                end else if (m_cnt == LIM - 1) begin
                    m_wait = 0; m_cnt = 0; m_exp = 1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end else if (wait_en && rise != 0 && !drq) begin
                m_wait = 1; m_cnt = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare outputs with the model on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            check(int'(cpu_wait) == m_wait, cur_req, "cpu_wait vs model", int'(cpu_wait), m_wait);
            check(int'(wd_expired) == m_exp, cur_req, "wd_expired vs model", int'(wd_expired), m_exp);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic pulse_access();
        data_access = 1'b1;
        tick();
        data_access = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_en = 1'b0; data_access = 1'b0; drq = 1'b0; intrq = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // wait for the current wait to end; return how many cycles it was seen high
    task automatic measure(output int len);
        len = 0;
        while (cpu_wait && len < 4 * LIM) begin
            len++;
            tick();
        end
    endtask

    int len;

    initial begin : watchdog_proc
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main_proc
        // R1 reset state
        cur_req = "R1";
        do_reset();
        check(cpu_wait == 1'b0, "R1", "cpu_wait after reset", int'(cpu_wait), 0);
        check(wd_expired == 1'b0, "R1", "wd_expired after reset", int'(wd_expired), 0);

        // R2 start, R5 release by drq
        cur_req = "R2";
        wait_en = 1'b1;
        tick();
        pulse_access();
        check(cpu_wait == 1'b1, "R2", "wait raised by access", int'(cpu_wait), 1);
        repeat (5) tick();
        cur_req = "R5";
        drq = 1'b1;
        tick();
        check(cpu_wait == 1'b0, "R5", "drq release", int'(cpu_wait), 0);
        check(wd_expired == 1'b0, "R5", "no expiry on drq", int'(wd_expired), 0);
        drq = 1'b0;
        tick();

        // R4 access with drq already high
        cur_req = "R4";
        drq = 1'b1;
        pulse_access();
        check(cpu_wait == 1'b0, "R4", "no wait with drq high", int'(cpu_wait), 0);
        drq = 1'b0;
        repeat (2) tick();

        // R3 disabled accesses and disable during wait
        cur_req = "R3";
        wait_en = 1'b0;
        pulse_access();
        check(cpu_wait == 1'b0, "R3", "no wait when disabled", int'(cpu_wait), 0);
        tick();
        wait_en = 1'b1;
        pulse_access();
        repeat (3) tick();
        wait_en = 1'b0;
        tick();
        check(cpu_wait == 1'b0, "R3", "disable ends wait", int'(cpu_wait), 0);
        wait_en = 1'b1;
        tick();

        // R6 release by intrq
        cur_req = "R6";
        pulse_access();
        repeat (7) tick();
        intrq = 1'b1;
        tick();
        check(cpu_wait == 1'b0, "R6", "intrq release", int'(cpu_wait), 0);
        check(wd_expired == 1'b0, "R6", "no expiry on intrq", int'(wd_expired), 0);
        intrq = 1'b0;
        tick();

        // R7 held strobe counts once
        cur_req = "R7";
        data_access = 1'b1;
        tick();
        repeat (3) tick();
        drq = 1'b1;
        tick();
        drq = 1'b0;
        repeat (4) tick();
        check(cpu_wait == 1'b0, "R7", "held strobe gives one wait", int'(cpu_wait), 0);
        data_access = 1'b0;
        tick();

        // R11 release at the limit cycle wins
        cur_req = "R11";
        pulse_access();
        repeat (LIM - 1) tick();
        check(cpu_wait == 1'b1, "R11", "still waiting before limit", int'(cpu_wait), 1);
        drq = 1'b1;
        tick();
        drq = 1'b0;
        check(cpu_wait == 1'b0, "R11", "released at limit", int'(cpu_wait), 0);
        check(wd_expired == 1'b0, "R11", "release wins over watchdog", int'(wd_expired), 0);
        tick();

        // R7 accesses during a wait do not restart; R8 full-length expiry
        cur_req = "R8";
        pulse_access();
        repeat (4) tick();
        data_access = 1'b1; tick(); data_access = 1'b0;
        repeat (3) tick();
        data_access = 1'b1; tick(); data_access = 1'b0;
        measure(len);
        check(len + 9 == LIM, "R7", "wait length with extra accesses", len + 9, LIM);
        check(wd_expired == 1'b1, "R8", "expired after limit", int'(wd_expired), 1);
        tick();

        // R10 counter restarts after early release; R9 sticky and waits still work
        cur_req = "R10";
        pulse_access();
        repeat (LIM - 6) tick();
        drq = 1'b1; tick(); drq = 1'b0;
        tick();
        pulse_access();
        measure(len);
        check(len == LIM, "R10", "full wait after restart", len, LIM);
        cur_req = "R9";
        check(wd_expired == 1'b1, "R9", "expired stays set", int'(wd_expired), 1);
        pulse_access();
        check(cpu_wait == 1'b1, "R9", "wait works after expiry", int'(cpu_wait), 1);
        intrq = 1'b1; tick(); intrq = 1'b0;
        check(wd_expired == 1'b1, "R9", "expired still set", int'(wd_expired), 1);
        do_reset();
        tick();
        check(wd_expired == 1'b0, "R9", "reset clears expired", int'(wd_expired), 0);

        // R8 plain expiry length from reset
        cur_req = "R8";
        wait_en = 1'b1;
        pulse_access();
        measure(len);
        check(len == LIM, "R8", "wait length without release", len, LIM);

        // random traffic against the model
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            wait_en     = ($urandom_range(0, 15) != 0);
            data_access = ($urandom_range(0, 3) == 0);
            drq         = ($urandom_range(0, 40) == 0);
            intrq       = ($urandom_range(0, 60) == 0);
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule